// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block computes a 24-bit single-error-correcting Hamming code over one 512-byte NAND sector while the sector's bytes stream through it, one byte per accepted strobe. It keeps twelve pairs of parity bits. Three column pairs split the eight bits of every byte by the bits of their bit index. Nine line pairs split the sector's bytes by the bits of their position in the sector. A controller writes a control word to clear the parity and arm the generator. It then feeds the sector bytes and, once the done flag rises, reads either the 32-bit result word or the packed three-byte code.

The code is not inverted. A sector of all-ones bytes gives an all-zero code, the same as an all-zero sector. Software that tells erased pages from written ones must account for this. The generator stops taking bytes once 512 have been accepted and waits for the next clear.

Top module: `nand_ecc_gen`

## Requirements
- R1: In the cycle after `rst` is high, `result`, `code` and `done` are zero, and accumulation is disabled until a control write sets the enable bit.
- R2: A control write (`ctl_wr` high) with `ctl_val` bit 8 set clears all parity bits, the byte position and `done`. `ctl_val` bit 0 sets (1) or drops (0) the enable. A control write with bit 8 clear leaves parity and byte position untouched.
- R3: A byte is accepted only when `byte_vld` is high, the block is enabled, `done` is low and no control write occurs in the same cycle. Otherwise it has no effect. The parity from an accepted byte is visible on `result` one cycle after the accepting clock edge.
- R4: Column parities sit in `result` bits 0, 1 and 2 (even, for weights 1, 2, 4) and bits 16, 17 and 18 (odd). For column k, the odd term XORs the data bits whose bit-index bit k is 1, and the even term XORs the bits where it is 0.
- R5: Line parities for weights 8 through 2048 sit in `result` bits 3 to 11 (even) and bits 19 to 27 (odd). For address bit m (0..8), the odd term XORs all data bits of the bytes whose position has bit m set, and the even term covers the others. The position counts accepted bytes from 0 after a clear.
- R6: `result` bits 15:12 and 31:28 are always zero.
- R7: `code` is {byte2, byte1, byte0}. byte0 = `result[7:0]`, byte1 = `result[23:16]`, and byte2 = {`result[27:24]`, `result[11:8]`}.
- R8: `done` rises one cycle after the 512th accepted byte. Later bytes are ignored and `done` holds until the next clear.
- R9: The code is not inverted: a sector of 512 bytes of 0xFF ends with `code` = 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_val | input | 16 | Control word: bit 8 clear, bit 0 enable |
| byte_vld | input | 1 | Data byte strobe |
| byte_dat | input | 8 | Data byte |
| done | output | 1 | Sector complete |
| result | output | 32 | Even parities in bits 11:0, odd parities in bits 27:16 |
| code | output | 24 | Packed three-byte code |

## Verification
Every result is due exactly one clock edge after its cause. Parity, `done` and `code` all reflect a byte, control write or reset in the first cycle after the edge that took it. The bench drives every input on the falling edge and samples at the next falling edge, half a cycle after the register updates. The expected parities come from a bit-by-bit reference model kept in the bench, and a few hand-worked single-bit sectors are compared against it as well. Idle strobes, disabled periods, colliding control writes and bytes after `done` are each followed by a read of `result` before any new accepted byte.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int CTL_W       = 16;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_CLR_BIT = 8;
  localparam int RES_W       = 32;
  localparam int ODD_BASE    = 16;
  localparam int CODE_W      = 24;

  // byte0: low even parities, byte1: low odd parities,
  // byte2: high even nibble below high odd nibble
  function automatic logic [CODE_W-1:0] pack_code(input logic [RES_W-1:0] r);
    return {r[ODD_BASE+11:ODD_BASE+8], r[11:8], r[ODD_BASE+7:ODD_BASE], r[7:0]};
  endfunction
endpackage

// File: rtl/ecc_col_terms.sv
module ecc_col_terms #(
  parameter int DATA_W = 8,
  parameter int COL_N  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic [COL_N-1:0]  odd_o,
  output logic [COL_N-1:0]  even_o,
  output logic              par_o
);
  // mask of bit positions whose index has bit j set
  function automatic logic [DATA_W-1:0] sel_mask(input int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = 1'((i >> j) & 1);
    return m;
  endfunction

  for (genvar g = 0; g < COL_N; g++) begin : g_col
    localparam logic [DATA_W-1:0] MASK = sel_mask(g);
    assign odd_o[g]  = ^(byte_i & MASK);
    assign even_o[g] = ^(byte_i & ~MASK);
  end

  assign par_o = ^byte_i;
endmodule

// File: rtl/ecc_seq_ctl.sv
module ecc_seq_ctl #(
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr_i,
  input  logic             ctl_clr_i,
  input  logic             ctl_en_i,
  input  logic             byte_vld_i,
  output logic             take_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES - 1);

  logic             en_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;

  // control write wins over a byte strobe in the same cycle
  assign take_o = en_q & ~done_q & byte_vld_i & ~ctl_wr_i;
  assign clr_o  = ctl_wr_i & ctl_clr_i;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ctl_wr_i) en_q <= ctl_en_i;
      if (clr_o) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (take_o) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) done_q <= 1'b1;
      end
    end
  end

  // R1: reset leaves the sequencer idle and disarmed
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!en_q && !done_q && cnt_q == '0));

  // R2: a clear returns position and done to the start
  a_r2_clear_restart: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> (cnt_q == '0 && !done_q));

  // R3: byte position moves only on an accepted byte
  a_r3_pos_stable: assert property (@(posedge clk) disable iff (rst)
    (!take_o && !clr_o) |=> $stable(cnt_q));

  // R8: done holds until a clear
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr_o) |=> done_q);

  // R8: done rises only once the position has wrapped
  a_r8_done_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (cnt_q == '0));
endmodule

// File: rtl/ecc_par_accum.sv
module ecc_par_accum #(
  parameter int DATA_W = 8,
  parameter int LINE_N = 9,
  parameter int COL_N  = $clog2(DATA_W),
  parameter int NP     = COL_N + LINE_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [LINE_N-1:0] addr_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [NP-1:0]     even_o,
  output logic [NP-1:0]     odd_o
);
  logic [COL_N-1:0] col_odd;
  logic [COL_N-1:0] col_even;
  logic             byte_par;
  logic [NP-1:0]    hit_odd;
  logic [NP-1:0]    hit_even;
  logic [NP-1:0]    even_q;
  logic [NP-1:0]    odd_q;

  ecc_col_terms #(.DATA_W(DATA_W), .COL_N(COL_N)) u_col (
    .byte_i (byte_i),
    .odd_o  (col_odd),
    .even_o (col_even),
    .par_o  (byte_par)
  );

  assign hit_odd[COL_N-1:0]  = col_odd;
  assign hit_even[COL_N-1:0] = col_even;

  // the whole byte's parity lands on one side of each line pair
  for (genvar m = 0; m < LINE_N; m++) begin : g_line
    assign hit_odd[COL_N+m]  = byte_par &  addr_i[m];
    assign hit_even[COL_N+m] = byte_par & ~addr_i[m];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (take_i) begin
      even_q <= even_q ^ hit_even;
      odd_q  <= odd_q  ^ hit_odd;
    end
  end

  assign even_o = even_q;
  assign odd_o  = odd_q;

  // R1: reset empties the parity registers
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (even_q == '0 && odd_q == '0));

  // R2: a clear empties the parity registers
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (even_q == '0 && odd_q == '0));

  // R3: no accepted byte, no parity change
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!take_i && !clr_i) |=> ($stable(even_q) && $stable(odd_q)));

  // R4, R5: every pair together flips by the byte's overall parity
  a_r5_pair_sum: assert property (@(posedge clk) disable iff (rst)
    (take_i && !clr_i) |=>
      (((even_q ^ odd_q) ^ $past(even_q ^ odd_q)) == {NP{$past(^byte_i)}}));
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_val,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_dat,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic [CODE_W-1:0] code
);
  localparam int COL_N  = $clog2(DATA_W);
  localparam int LINE_N = $clog2(SECTOR_BYTES);
  localparam int NP     = COL_N + LINE_N;

  logic              take;
  logic              clr;
  logic [LINE_N-1:0] pos;
  logic [NP-1:0]     even_par;
  logic [NP-1:0]     odd_par;
  logic              ctl_unused;

  assign ctl_unused = ^{ctl_val[CTL_W-1:CTL_CLR_BIT+1], ctl_val[CTL_CLR_BIT-1:CTL_EN_BIT+1]};

  ecc_seq_ctl #(.SECTOR_BYTES(SECTOR_BYTES), .CNT_W(LINE_N)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr_i   (ctl_wr),
    .ctl_clr_i  (ctl_val[CTL_CLR_BIT]),
    .ctl_en_i   (ctl_val[CTL_EN_BIT]),
    .byte_vld_i (byte_vld),
    .take_o     (take),
    .clr_o      (clr),
    .cnt_o      (pos),
    .done_o     (done)
  );

  ecc_par_accum #(.DATA_W(DATA_W), .LINE_N(LINE_N), .COL_N(COL_N), .NP(NP)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .take_i (take),
    .addr_i (pos),
    .byte_i (byte_dat),
    .even_o (even_par),
    .odd_o  (odd_par)
  );

  always_comb begin
    result = '0;
    result[NP-1:0] = even_par;
    result[ODD_BASE +: NP] = odd_par;
  end

  assign code = pack_code(result);
endmodule

// File: tb/sim_nand_ecc_gen.sv
module sim_nand_ecc_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_val = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_dat = '0;
  logic        done;
  logic [31:0] result;
  logic [23:0] code;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] sec_mem [512];

  always #4 clk = ~clk;

  nand_ecc_gen u0 (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_val(ctl_val),
    .byte_vld(byte_vld), .byte_dat(byte_dat),
    .done(done), .result(result), .code(code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // mode, position, bit, fill byte, expected result, expected code
  localparam logic [77:0] VEC [6] = '{
    {2'd0, 9'd0,   3'd0, 8'h00, 32'h00000000, 24'h000000},
    {2'd0, 9'd0,   3'd0, 8'hFF, 32'h00000000, 24'h000000},
    {2'd1, 9'd0,   3'd0, 8'h00, 32'h00000FFF, 24'h0F00FF},
    {2'd1, 9'd511, 3'd7, 8'h00, 32'h0FFF0000, 24'hF0FF00},
    {2'd1, 9'd341, 3'd5, 8'h00, 32'h0AAD0552, 24'hA5AD52},
    {2'd1, 9'd256, 3'd3, 8'h00, 32'h080307FC, 24'h8703FC}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // bit-by-bit reference: every set bit toggles one side of each pair
  function automatic logic [31:0] ref_model();
    logic [11:0] ev = '0;
    logic [11:0] od = '0;
    for (int a = 0; a < 512; a++)
      for (int b = 0; b < 8; b++)
        if (sec_mem[a][b]) begin
          for (int k = 0; k < 3; k++)
            if ((b >> k) & 1) od[k] = ~od[k]; else ev[k] = ~ev[k];
          for (int m = 0; m < 9; m++)
            if ((a >> m) & 1) od[3+m] = ~od[3+m]; else ev[3+m] = ~ev[3+m];
        end
    return {4'h0, od, 4'h0, ev};
  endfunction

  function automatic logic [23:0] ref_pack(input logic [31:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic ctl(input logic [15:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_val = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_val = '0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_dat = b;
    @(negedge clk);
    byte_vld = 1'b0; byte_dat = '0;
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; byte_dat = sec_mem[i];
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        byte_vld = 1'b0;
      end
    end
    @(negedge clk);
    byte_vld = 1'b0; byte_dat = '0;
  endtask

  initial begin
    logic [31:0] exp_r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset result", result, 32'h0);
    chk("R1 reset code", {8'h0, code}, 32'h0);
    chk("R1 reset done", {31'h0, done}, 32'h0);
    // R1: not yet enabled, a byte has no effect
    put(8'h01);
    chk("R1 disabled after reset", result, 32'h0);

    // vector table walk: R4 R5 R7 R8 R9
    for (int v = 0; v < 6; v++) begin
      for (int a = 0; a < 512; a++) sec_mem[a] = VEC[v][63:56];
      if (VEC[v][77:76] == 2'd1) sec_mem[VEC[v][75:67]][VEC[v][66:64]] = 1'b1;
      ctl(16'h0101);
      feed(512, v[0]);
      chk($sformatf("R4 R5 vector %0d result", v), result, VEC[v][55:24]);
      chk($sformatf("R5 vector %0d model", v), result, ref_model());
      chk($sformatf("R7 R9 vector %0d code", v), {8'h0, code}, {8'h0, VEC[v][23:0]});
      chk($sformatf("R8 vector %0d done", v), {31'h0, done}, 32'h1);
    end

    // ramp sector with idle gaps, checked against the model
    for (int a = 0; a < 512; a++) sec_mem[a] = 8'(a * 37 + (a >> 3));
    ctl(16'h0101);
    feed(512, 1'b1);
    exp_r = ref_model();
    chk("R4 R5 ramp result", result, exp_r);
    chk("R7 ramp code", {8'h0, code}, {8'h0, ref_pack(exp_r)});
    chk("R6 ramp reserved", result & 32'hF000F000, 32'h0);
    // R8: bytes after done are ignored
    put(8'h5A); put(8'h01); put(8'h80);
    chk("R8 ignored after done", result, exp_r);
    chk("R8 done held", {31'h0, done}, 32'h1);

    // R2: clear plus disable, then a byte is ignored (R3)
    ctl(16'h0100);
    chk("R2 clear result", result, 32'h0);
    chk("R2 clear done", {31'h0, done}, 32'h0);
    put(8'h01);
    chk("R3 disabled byte ignored", result, 32'h0);
    // enable without clear, byte at position 0
    ctl(16'h0001);
    put(8'h01);
    chk("R2 R4 enable no clear", result, 32'h00000FFF);
    // disable without clear keeps parity
    ctl(16'h0000);
    chk("R2 disable keeps parity", result, 32'h00000FFF);
    put(8'h80);
    chk("R3 disabled keeps parity", result, 32'h00000FFF);
    // re-enable: position 1 preserved
    ctl(16'h0001);
    put(8'h80);
    chk("R5 position kept across disable", result, 32'h000F000F);
    // R3: control write and byte strobe in the same cycle, byte dropped
    @(negedge clk);
    ctl_wr = 1'b1; ctl_val = 16'h0001; byte_vld = 1'b1; byte_dat = 8'h01;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_val = '0; byte_vld = 1'b0; byte_dat = '0;
    chk("R3 collision byte dropped", result, 32'h000F000F);
    // idle strobe-free cycles
    repeat (4) @(negedge clk);
    chk("R3 idle stable", result, 32'h000F000F);

    // R8 boundary: done only after the 512th byte
    for (int a = 0; a < 512; a++) sec_mem[a] = 8'h00;
    ctl(16'h0101);
    feed(511, 1'b0);
    chk("R8 not done at 511", {31'h0, done}, 32'h0);
    put(8'h00);
    chk("R8 done at 512", {31'h0, done}, 32'h1);

    // R1: reset mid-run disarms and empties
    ctl(16'h0101);
    put(8'h01);
    chk("R4 single byte before reset", result, 32'h00000FFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears parity", result, 32'h0);
    put(8'h01);
    chk("R1 reset disarms", result, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule